// File: doc/BRIEF.md
# Raster Timing Generator with Blank Control

This block produces the horizontal sync, vertical sync, blank and frame-start strobes for a raster display. Everything comes from a small set of programmable timing registers, and the block also supplies the byte address at which the visible frame begins. A single clock enable tick equals one horizontal unit of two pixels, so the block is clocked at half the dot rate. The vertical axis is counted in half-lines: the vertical counter steps by two at every line end, and every vertical register is written in half-line units.

Software programs the registers through a plain one-cycle write port. The timing registers and the scroll/pitch registers are double-buffered. A write lands in a shadow copy, and all shadow copies move into the live set together on the clock edge that starts a new frame, so a frame is never drawn with mixed settings. The control register is not buffered. It can blank the picture while the counters keep running, and it can switch off each sync output on its own for display power-saving states.

Top module: `raster_timing`

## Requirements
- R1: The horizontal counter runs from 0 to HT+1, where HT is the value in register 0, giving a line period of HT+2 units. Horizontal sync is high at unit HT+1 and, after the wrap, at units 0 to HE-1, where HE is register 3. That makes a pulse of HE+1 units per line.
- R2: The horizontal active window covers the units u with HBE ≤ u < HBS, where HBS is register 1 and HBE is register 2. All other units are horizontally blanked.
- R3: The vertical counter holds an even half-line count. It advances by 2 at each line end and wraps to 0 after VP-2, where VP is register 4 (an even value). A frame therefore lasts VP/2 lines. Vertical sync is high when the count is at least VP-2 or below VE, where VE is register 7.
- R4: The vertical active window covers the counts v with VBE ≤ v < VBS, where VBS is register 5 and VBE is register 6. The blank output is high unless both the horizontal and the vertical position lie inside their active windows.
- R5: frame_start is high in exactly the one cycle per frame in which both counters are 0.
- R6: Writes to registers 0–7 change no output until the first cycle of the next frame. From that cycle on, the new values define the timing.
- R7: Control register (address 8) bit 10 forces blank high from the cycle after the write. The counters, the sync outputs and frame_start keep running unchanged.
- R8: Horizontal sync reaches its pin only while control bits 5 and 4 are both 1. Vertical sync reaches its pin only while control bits 1 and 0 are both 1. Clearing either bit of a pair holds that output low from the cycle after the write.
- R9: start_addr equals Y·(P with its low 5 bits cleared) + (X' << D). Here P is the pitch (address 9), Y is the vertical offset (address 11), and D is the depth code in bits 1:0 of address 12: code 0 means 1 byte per pixel, 1 means 2, 2 means 4, and 3 is treated as 2. X' is the horizontal offset (address 10) rounded up to a multiple of 32>>D. The result is always a multiple of 32.
- R10: start_addr changes only on the edge that begins a frame. Writes to addresses 9–12 are not visible at start_addr before that edge.
- R11: Reset sets both counters to 0 and loads the default timing. It sets the control register to 0x0033 (syncs enabled, no forced blank) and start_addr to 0.
- R12: A write to an address of 13 or above changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per two-pixel unit |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW | Register write data |
| hsync | output | 1 | Horizontal sync, gated by control bits 5:4 |
| vsync | output | 1 | Vertical sync, gated by control bits 1:0 |
| blank | output | 1 | High outside the active picture or when forced |
| frame_start | output | 1 | High in the first unit of each frame |
| start_addr | output | AW | Byte address of the first visible pixel |

## Verification
A horizontal counter that slips shows up within one line, as an hsync pulse of the wrong width or position. A wrong vertical count or wrap shows up within one frame, as a vsync of the wrong length or a frame_start pulse at the wrong spacing. A shadow register that loads at the wrong moment changes the line length, the frame length or start_addr in the middle of a frame. It is caught in the same cycle it happens, because a cycle-accurate reference runs beside the block and compares all five outputs every cycle. Directed frames add checks on pulse counts, active-cycle counts and the double-buffering boundary.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Register addresses decoded by the write port.
  localparam logic [3:0] RA_HTOT   = 4'd0;
  localparam logic [3:0] RA_HBSTRT = 4'd1;
  localparam logic [3:0] RA_HBEND  = 4'd2;
  localparam logic [3:0] RA_HSEND  = 4'd3;
  localparam logic [3:0] RA_VPER   = 4'd4;
  localparam logic [3:0] RA_VBSTRT = 4'd5;
  localparam logic [3:0] RA_VBEND  = 4'd6;
  localparam logic [3:0] RA_VSEND  = 4'd7;
  localparam logic [3:0] RA_CTRL   = 4'd8;
  localparam logic [3:0] RA_PITCH  = 4'd9;
  localparam logic [3:0] RA_XOFF   = 4'd10;
  localparam logic [3:0] RA_YOFF   = 4'd11;
  localparam logic [3:0] RA_DEPTH  = 4'd12;

  // Control register bit positions.
  localparam int CB_VS_LO   = 0;
  localparam int CB_VS_HI   = 1;
  localparam int CB_HS_LO   = 4;
  localparam int CB_HS_HI   = 5;
  localparam int CB_FBLANK  = 10;

  localparam logic [15:0] CTRL_RESET = 16'h0033;

  // Alignment of the frame start address, in address bits.
  localparam int ALIGN_BITS = 5;

endpackage

// File: rtl/rt_hcount.sv
module rt_hcount #(
  parameter int HW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] htot,
  output logic [HW-1:0] hc,
  output logic          line_end
);

  logic [HW:0] last_unit;

  assign last_unit = {1'b0, htot} + (HW+1)'(1);
  assign line_end  = ({1'b0, hc} >= last_unit);

  always_ff @(posedge clk) begin
    if (rst)
      hc <= '0;
    else if (line_end)
      hc <= '0;
    else
      hc <= hc + HW'(1);
  end

  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hc == '0)); // R1

  AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> (hc == $past(hc) + HW'(1))); // R1

endmodule

// File: rtl/rt_vcount.sv
module rt_vcount #(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [VW-1:0] vper,
  output logic [VW-1:0] vc,
  output logic          last_line,
  output logic          frame_edge
);

  logic [VW:0] vc_next_line;

  assign vc_next_line = {1'b0, vc} + (VW+1)'(2);
  assign last_line    = (vc_next_line >= {1'b0, vper});
  assign frame_edge   = line_end && last_line;

  always_ff @(posedge clk) begin
    if (rst)
      vc <= '0;
    else if (frame_edge)
      vc <= '0;
    else if (line_end)
      vc <= vc + VW'(2);
  end

  AST_V_EVEN: assert property (@(posedge clk) disable iff (rst)
    vc[0] == 1'b0); // R3

  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(vc)); // R3

  AST_V_WRAP: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> (vc == '0)); // R3

endmodule

// File: rtl/rt_addr.sv
module rt_addr #(
  parameter int PW = 16,
  parameter int OW = 12,
  parameter int AW = 28
) (
  input  logic [PW-1:0] pitch,
  input  logic [OW-1:0] xoff,
  input  logic [OW-1:0] yoff,
  input  logic [1:0]    depth,
  output logic [AW-1:0] addr
);
  import raster_pkg::*;

  localparam int ALIGN_MAX = (1 << ALIGN_BITS) - 1;

  logic [1:0]    shift;
  logic [AW-1:0] step_mask;
  logic [AW-1:0] x_round;
  logic [AW-1:0] x_bytes;
  logic [AW-1:0] pitch_al;
  logic [AW-1:0] row_bytes;

  always_comb begin
    shift     = (depth == 2'd3) ? 2'd2 : depth;
    step_mask = AW'(ALIGN_MAX) >> shift;
    x_round   = (AW'(xoff) + step_mask) & ~step_mask;
    x_bytes   = x_round << shift;
    pitch_al  = AW'(pitch) & ~AW'(ALIGN_MAX);
    row_bytes = AW'(yoff) * pitch_al;
    addr      = row_bytes + x_bytes;
  end

endmodule

// File: rtl/rt_regs.sv
module rt_regs #(
  parameter int          HW       = 12,
  parameter int          VW       = 12,
  parameter int          DW       = 16,
  parameter int          PW       = 16,
  parameter int          OW       = 12,
  parameter int          AW       = 28,
  parameter logic [HW-1:0] DEF_HTOT = 10,
  parameter logic [HW-1:0] DEF_HBS  = 9,
  parameter logic [HW-1:0] DEF_HBE  = 2,
  parameter logic [HW-1:0] DEF_HSE  = 1,
  parameter logic [VW-1:0] DEF_VPER = 16,
  parameter logic [VW-1:0] DEF_VBS  = 12,
  parameter logic [VW-1:0] DEF_VBE  = 4,
  parameter logic [VW-1:0] DEF_VSE  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_edge,
  input  logic [AW-1:0] addr_calc,
  output logic [HW-1:0] act_htot,
  output logic [HW-1:0] act_hbs,
  output logic [HW-1:0] act_hbe,
  output logic [HW-1:0] act_hse,
  output logic [VW-1:0] act_vper,
  output logic [VW-1:0] act_vbs,
  output logic [VW-1:0] act_vbe,
  output logic [VW-1:0] act_vse,
  output logic [DW-1:0] ctrl,
  output logic [PW-1:0] sh_pitch,
  output logic [OW-1:0] sh_xoff,
  output logic [OW-1:0] sh_yoff,
  output logic [1:0]    sh_depth,
  output logic [AW-1:0] act_addr
);
  import raster_pkg::*;

  localparam int NAXREG = 4;

  logic [HW-1:0] sh_h  [NAXREG];
  logic [HW-1:0] act_h [NAXREG];
  logic [VW-1:0] sh_v  [NAXREG];
  logic [VW-1:0] act_v [NAXREG];

  function automatic logic [HW-1:0] h_default(input int idx);
    case (idx)
      0:       return DEF_HTOT;
      1:       return DEF_HBS;
      2:       return DEF_HBE;
      default: return DEF_HSE;
    endcase
  endfunction

  function automatic logic [VW-1:0] v_default(input int idx);
    case (idx)
      0:       return DEF_VPER;
      1:       return DEF_VBS;
      2:       return DEF_VBE;
      default: return DEF_VSE;
    endcase
  endfunction

  // Horizontal group sits at addresses 0..3, vertical group at 4..7.
  for (genvar i = 0; i < NAXREG; i++) begin : g_axis
    logic hit_h;
    logic hit_v;
    assign hit_h = wr_en && (wr_addr == 4'(i));
    assign hit_v = wr_en && (wr_addr == 4'(i + NAXREG));

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_h[i]  <= h_default(i);
        act_h[i] <= h_default(i);
        sh_v[i]  <= v_default(i);
        act_v[i] <= v_default(i);
      end else begin
        if (frame_edge) begin
          act_h[i] <= sh_h[i];
          act_v[i] <= sh_v[i];
        end
        if (hit_h) sh_h[i] <= wr_data[HW-1:0];
        if (hit_v) sh_v[i] <= wr_data[VW-1:0];
      end
    end
  end

  assign act_htot = act_h[0];
  assign act_hbs  = act_h[1];
  assign act_hbe  = act_h[2];
  assign act_hse  = act_h[3];
  assign act_vper = act_v[0];
  assign act_vbs  = act_v[1];
  assign act_vbe  = act_v[2];
  assign act_vse  = act_v[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= DW'(CTRL_RESET);
      sh_pitch <= '0;
      sh_xoff  <= '0;
      sh_yoff  <= '0;
      sh_depth <= '0;
      act_addr <= '0;
    end else begin
      if (frame_edge) act_addr <= addr_calc;
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL:  ctrl     <= wr_data;
          RA_PITCH: sh_pitch <= wr_data[PW-1:0];
          RA_XOFF:  sh_xoff  <= wr_data[OW-1:0];
          RA_YOFF:  sh_yoff  <= wr_data[OW-1:0];
          RA_DEPTH: sh_depth <= wr_data[1:0];
          default:  ;
        endcase
      end
    end
  end

  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_edge |=> ($stable(act_htot) && $stable(act_vper))); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_edge |=> $stable(act_addr)); // R10

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    act_addr[ALIGN_BITS-1:0] == '0); // R9

endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int          HW       = 12,
  parameter int          VW       = 12,
  parameter int          DW       = 16,
  parameter int          PW       = 16,
  parameter int          OW       = 12,
  parameter int          AW       = 28,
  parameter logic [HW-1:0] DEF_HTOT = 10,
  parameter logic [HW-1:0] DEF_HBS  = 9,
  parameter logic [HW-1:0] DEF_HBE  = 2,
  parameter logic [HW-1:0] DEF_HSE  = 1,
  parameter logic [VW-1:0] DEF_VPER = 16,
  parameter logic [VW-1:0] DEF_VBS  = 12,
  parameter logic [VW-1:0] DEF_VBE  = 4,
  parameter logic [VW-1:0] DEF_VSE  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          frame_start,
  output logic [AW-1:0] start_addr
);
  import raster_pkg::*;

  logic [HW-1:0] act_htot, act_hbs, act_hbe, act_hse;
  logic [VW-1:0] act_vper, act_vbs, act_vbe, act_vse;
  logic [DW-1:0] ctrl;
  logic [PW-1:0] sh_pitch;
  logic [OW-1:0] sh_xoff, sh_yoff;
  logic [1:0]    sh_depth;
  logic [AW-1:0] addr_calc;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic          line_end, last_line, frame_edge;
  logic          hs_raw, vs_raw, h_act, v_act;
  logic          hs_gate, vs_gate;

  rt_regs #(
    .HW(HW), .VW(VW), .DW(DW), .PW(PW), .OW(OW), .AW(AW),
    .DEF_HTOT(DEF_HTOT), .DEF_HBS(DEF_HBS), .DEF_HBE(DEF_HBE), .DEF_HSE(DEF_HSE),
    .DEF_VPER(DEF_VPER), .DEF_VBS(DEF_VBS), .DEF_VBE(DEF_VBE), .DEF_VSE(DEF_VSE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_edge(frame_edge), .addr_calc(addr_calc),
    .act_htot(act_htot), .act_hbs(act_hbs), .act_hbe(act_hbe), .act_hse(act_hse),
    .act_vper(act_vper), .act_vbs(act_vbs), .act_vbe(act_vbe), .act_vse(act_vse),
    .ctrl(ctrl), .sh_pitch(sh_pitch), .sh_xoff(sh_xoff), .sh_yoff(sh_yoff),
    .sh_depth(sh_depth), .act_addr(start_addr)
  );

  rt_addr #(.PW(PW), .OW(OW), .AW(AW)) u_addr (
    .pitch(sh_pitch), .xoff(sh_xoff), .yoff(sh_yoff), .depth(sh_depth),
    .addr(addr_calc)
  );

  rt_hcount #(.HW(HW)) u_hcnt (
    .clk(clk), .rst(rst), .htot(act_htot), .hc(hc), .line_end(line_end)
  );

  rt_vcount #(.VW(VW)) u_vcnt (
    .clk(clk), .rst(rst), .line_end(line_end), .vper(act_vper),
    .vc(vc), .last_line(last_line), .frame_edge(frame_edge)
  );

  always_comb begin
    // Sync pulses start at the last position and wrap past zero.
    hs_raw  = line_end  || (hc < act_hse);
    vs_raw  = last_line || (vc < act_vse);
    h_act   = (hc >= act_hbe) && (hc < act_hbs);
    v_act   = (vc >= act_vbe) && (vc < act_vbs);
    hs_gate = ctrl[CB_HS_HI] && ctrl[CB_HS_LO];
    vs_gate = ctrl[CB_VS_HI] && ctrl[CB_VS_LO];
    hsync       = hs_raw && hs_gate;
    vsync       = vs_raw && vs_gate;
    blank       = ctrl[CB_FBLANK] || !(h_act && v_act);
    frame_start = (hc == '0) && (vc == '0);
  end

  AST_FORCE_BLANK: assert property (@(posedge clk) disable iff (rst)
    ctrl[CB_FBLANK] |-> blank); // R7

  AST_HS_GATED: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[CB_HS_HI] && ctrl[CB_HS_LO]) |-> !hsync); // R8

  AST_VS_GATED: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[CB_VS_HI] && ctrl[CB_VS_LO]) |-> !vsync); // R8

  AST_FS_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> frame_start); // R5

endmodule

// File: tb/test_raster_timing.sv
module test_raster_timing;

  localparam int AW = 28;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          hsync, vsync, blank, frame_start;
  logic [AW-1:0] start_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  raster_timing i_raster_timing (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .blank(blank), .frame_start(frame_start),
    .start_addr(start_addr)
  );

  // ---------------- reference model (from the requirements) ----------------
  int sh [13];
  int ac [8];
  int m_ctrl, m_h, m_v, m_addr;
  logic [AW+3:0] exp_q [$];

  function automatic int calc_addr(int pitch, int xo, int yo, int dp);
    int d, stp, xr;
    d   = (dp == 3) ? 2 : dp;
    stp = 31 >> d;
    xr  = (xo + stp) & ~stp;
    return yo * (pitch & ~31) + (xr << d);
  endfunction

  task automatic model_reset();
    sh[0] = 10; sh[1] = 9; sh[2] = 2; sh[3] = 1;
    sh[4] = 16; sh[5] = 12; sh[6] = 4; sh[7] = 2;
    sh[8] = 0; sh[9] = 0; sh[10] = 0; sh[11] = 0; sh[12] = 0;
    for (int i = 0; i < 8; i++) ac[i] = sh[i];
    m_ctrl = 'h33; m_h = 0; m_v = 0; m_addr = 0;
  endtask

  function automatic logic [AW+3:0] model_out();
    logic hs, vs, bl, fs;
    hs = ((m_h == ac[0] + 1) || (m_h < ac[3])) && (((m_ctrl >> 4) & 3) == 3);
    vs = ((m_v >= ac[4] - 2) || (m_v < ac[7])) && ((m_ctrl & 3) == 3);
    bl = ((m_ctrl >> 10) & 1) != 0 ||
         !((m_h >= ac[2]) && (m_h < ac[1]) && (m_v >= ac[6]) && (m_v < ac[5]));
    fs = (m_h == 0) && (m_v == 0);
    return {hs, vs, bl, fs, AW'(m_addr)};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      bit le, fe;
      le = (m_h == ac[0] + 1);
      fe = le && (m_v + 2 >= ac[4]);
      if (fe) begin
        for (int i = 0; i < 8; i++) ac[i] = sh[i];
        m_addr = calc_addr(sh[9], sh[10], sh[11], sh[12] & 3);
      end
      m_h = le ? 0 : m_h + 1;
      m_v = fe ? 0 : (le ? m_v + 2 : m_v);
      if (wr_en && wr_addr <= 12) begin
        if (wr_addr == 8) m_ctrl = int'(wr_data);
        else sh[wr_addr] = int'(wr_data);
      end
    end
    exp_q.push_back(model_out());
  end

  // ---------------- monitor / scoreboard ----------------
  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0 && !done) begin
      logic [AW+3:0] e;
      e = exp_q.pop_front();
      chk(hsync == e[AW+3], "R1/R8 hsync", hsync, e[AW+3]);
      chk(vsync == e[AW+2], "R3/R8 vsync", vsync, e[AW+2]);
      chk(blank == e[AW+1], "R2/R4/R7 blank", blank, e[AW+1]);
      chk(frame_start == e[AW], "R5 frame_start", frame_start, e[AW]);
      chk(start_addr == e[AW-1:0], "R9/R10 start_addr", int'(start_addr), int'(e[AW-1:0]));
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  // Starting at a frame_start cycle, run one frame and count events.
  task automatic run_frame(output int n, output int nhs, output int nvs,
                           output int nact, output int nfs);
    n = 0; nhs = 0; nvs = 0; nact = 0; nfs = 0;
    do begin
      n++;
      nhs  += hsync;
      nvs  += vsync;
      nact += !blank;
      nfs  += frame_start;
      @(negedge clk);
    end while (!frame_start);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, nhs, nvs, nact, nfs, cnt;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk(frame_start == 1'b1, "R11 reset frame_start", frame_start, 1);
    chk(start_addr == '0, "R11 reset start_addr", int'(start_addr), 0);
    chk(hsync == 1'b1 && vsync == 1'b1, "R11 reset syncs enabled", {hsync, vsync}, 3);
    rst = 1'b0;
    wait_fs();

    // R1, R3: default frame is 12 units x 8 lines
    run_frame(n, nhs, nvs, nact, nfs);
    chk(n == 96, "R1/R3 default frame length", n, 96);
    chk(nhs == 16, "R1 hsync units per frame", nhs, 16);
    chk(nvs == 24, "R3 vsync units per frame", nvs, 24);

    // R6: mid-frame write of the line total does not shorten this frame
    cnt = 0;
    repeat (10) begin @(negedge clk); cnt++; end
    wr(0, 4); cnt += 2;
    do begin @(negedge clk); cnt++; end while (!frame_start);
    chk(cnt == 96, "R6 frame after mid-frame write keeps old length", cnt, 96);
    run_frame(n, nhs, nvs, nact, nfs);
    chk(n == 48, "R6/R1 new line total applied next frame", n, 48);

    // R3: vertical period change (5 lines)
    wr(4, 10);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(n == 30, "R3 vertical period 10 half-lines", n, 30);
    chk(nhs == 10, "R1 sync wraps, HE+1 units per line", nhs, 10);
    chk(nvs == 12, "R3 vsync spans wrap", nvs, 12);
    chk(nact == 12, "R2/R4 active window count", nact, 12);
    chk(nfs == 1, "R5 one frame_start per frame", nfs, 1);

    // R12: write to an unused address changes nothing
    wr(13, 'hFFFF);
    wr(15, 0);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(n == 30 && nact == 12, "R12 unused address ignored", n, 30);

    // R9/R10: scroll registers latch only at frame start
    repeat (3) @(negedge clk);
    wr(9, 640); wr(10, 5); wr(11, 3); wr(12, 1);
    chk(start_addr == '0, "R10 start_addr held mid-frame", int'(start_addr), 0);
    wait_fs();
    chk(start_addr == 28'd1952, "R9 addr depth 2 bytes", int'(start_addr), 1952);
    wr(9, 100); wr(10, 33); wr(11, 2); wr(12, 0);
    wait_fs();
    chk(start_addr == 28'd256, "R9 addr depth 1 byte, pitch low bits ignored", int'(start_addr), 256);
    wr(9, 0); wr(10, 9); wr(12, 3);
    wait_fs();
    chk(start_addr == 28'd64, "R9 depth code 3 as 4 bytes", int'(start_addr), 64);

    // R7: forced blank keeps timing running
    wr(8, 'h433);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(nact == 0, "R7 forced blank active count", nact, 0);
    chk(n == 30 && nhs == 10, "R7 timing continues while blanked", n, 30);

    // R8: sync gating pairs
    wr(8, 'h13);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(nhs == 0 && nvs == 12, "R8 hsync off with bit5 clear", nhs, 0);
    wr(8, 'h23);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(nhs == 0, "R8 hsync off with bit4 clear", nhs, 0);
    wr(8, 'h31);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(nvs == 0 && nhs == 10, "R8 vsync off with bit1 clear", nvs, 0);
    wr(8, 'h33);
    wait_fs();
    run_frame(n, nhs, nvs, nact, nfs);
    chk(nvs == 12 && nhs == 10 && nact == 12, "R8 syncs restored", nvs, 12);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule